// File: doc/BRIEF.md
# Two-Wire Block-Access Configuration Slave

This block is a slave on a two-wire serial bus (I2C/SMBus signalling). It fills a small bank of 8-bit control registers and lets a host read them back. The system clock oversamples both bus lines. Each line passes through a two-flop synchronizer and a glitch filter. The filtered lines are then decoded into SCL rising and falling edges and into START and STOP events. The slave drives SDA only by pulling it low, through the `sda_oe` output. Each register bit normally gates one downstream output. The block presents the bank as a flat vector, with register i at bits `[8*i +: 8]`. It raises a one-cycle pulse for each register it updates.

Only block transfers are supported. In a write, the host sends the address byte, then a command byte, then a count byte. The slave acknowledges both of those bytes and throws them away. Data bytes follow and land in registers 0, 1, 2 and so on, in ascending order. In a read, the slave returns a count byte and then the whole readback window. All bytes travel MSB first. The host must keep each SCL phase, and each SDA set-up before SCL rises, longer than about twelve system clocks. This gives margin over the synchronizer, the filter and the FSM latency. With the default 3-cycle filter, a 50 MHz system clock easily serves a 100 kbit/s bus.

The controller is one FSM with these states:

| State | Role |
|---|---|
| `ST_IDLE` | After reset or a STOP. |
| `ST_ADDR` | Shifts in the address byte. |
| `ST_ADDR_ACK` | Drives the address ACK. |
| `ST_WR_BYTE` | Shifts in a write byte. |
| `ST_WR_ACK` | Drives the ACK for a write byte. The register is committed on the rising SCL of this ACK clock. |
| `ST_RD_BYTE` | Shifts out a read byte. |
| `ST_RD_ACK` | Samples the host's acknowledge. |
| `ST_WAIT` | Bus belongs to someone else, or the host sent a NACK. |

The transitions are:

- A START enters `ST_ADDR` from any state.
- A STOP enters `ST_IDLE` from any state.
- `ST_ADDR` moves on the eighth SCL falling edge: to `ST_ADDR_ACK` on a match, otherwise to `ST_WAIT`.
- `ST_ADDR_ACK` moves on SCL falling: to `ST_RD_BYTE` for a read, or to `ST_WR_BYTE` for a write.
- `ST_WR_BYTE` moves to `ST_WR_ACK` after eight bits.
- `ST_WR_ACK` returns to `ST_WR_BYTE`.
- `ST_RD_BYTE` moves to `ST_RD_ACK` after eight bits.
- `ST_RD_ACK` moves to `ST_RD_BYTE` if the host acknowledged, otherwise to `ST_WAIT`.

Top module: `smb_cfg_slave`

## Requirements
- R1: The address byte 0xD2 (7-bit address 0x69, low bit 0) is acknowledged as a write and 0xD3 as a read. Any other address byte gets no ACK. Later bytes up to the next START also get no ACK and change no register.
- R2: In a write, the first two bytes after the address are acknowledged and discarded. They cause no register change and no update pulse.
- R3: Each data byte after those two is acknowledged and stored. Stores go to registers 0, 1, 2… in ascending order; register i appears on `reg_bank[8*i +: 8]`.
- R4: A register is written on the rising SCL of its ACK clock, with exactly one `reg_updated` pulse per stored byte. A STOP in the middle of a byte leaves every register unchanged.
- R5: A STOP ends the transaction. A later write restarts at register 0.
- R6: A read returns, MSB first, a count byte of value 7 and then registers 0 to 6. Register indices without storage return 0xFF.
- R7: During and after reset, every register reads 0xFF and SDA is released.
- R8: Only the implemented bits are writable: register 0 bits 3:0, register 1 bits 7:4, register 2 bits 7:6. Every other bit always reads 1.
- R9: Data bytes beyond the last register (index 3 and up) are acknowledged but not stored, and produce no pulse.
- R10: After the host sends a NACK for a read byte, the slave releases SDA and drives nothing until the next START or STOP.
- R11: A pulse on SCL or SDA that lasts fewer than FILT_CYCLES system clocks is ignored. It causes no extra bit, no START and no STOP.
- R12: `sda_oe` only begins pulling SDA low while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous-assert reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| reg_bank | output | 8*REG_COUNT | Register bank, register i at bits [8*i +: 8] |
| reg_updated | output | REG_COUNT | One-cycle pulse, bit i when register i is written |

## Verification
If the bit counter or the state is off by one, the host sees it within one byte. Either the ACK slot of the wrong clock is driven low, or a missing ACK shows up on `sda_oe`. If the byte index is wrong, the data lands in a neighbouring slice of `reg_bank` at the end of that ACK clock. On readback, the same fault shows as a shifted or 0xFF byte. If the filter or the edge decoder is faulty, a short pulse becomes a spurious bit or START. The write then shifts and is visible on the bank after STOP, and the update-pulse count no longer matches the number of stored bytes.

// File: rtl/cfgslv_pkg.sv
package cfgslv_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK,
        ST_WAIT
    } slv_state_e;

    localparam int unsigned BYTE_BITS = 8;
    localparam logic [7:0]  EMPTY_BYTE = 8'hFF;

endpackage

// File: rtl/cfgslv_line_filter.sv
module cfgslv_line_filter #(
    parameter int unsigned FILT_CYCLES = 3,
    parameter bit          IDLE_LEVEL  = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic clean_o
);
    localparam int unsigned CW = $clog2(FILT_CYCLES + 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q  <= {2{IDLE_LEVEL}};
            clean_o <= IDLE_LEVEL;
            run_q   <= '0;
        end else begin
            sync_q <= {sync_q[0], raw_i};
            if (sync_q[1] != clean_o) begin
                if (run_q == CW'(FILT_CYCLES - 1)) begin
                    clean_o <= sync_q[1];
                    run_q   <= '0;
                end else begin
                    run_q <= run_q + CW'(1);
                end
            end else begin
                run_q <= '0;
            end
        end
    end

    // R11: the filtered level only moves toward the synchronized level
    p_filter_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(clean_o) |-> ($past(sync_q[1]) == clean_o));

endmodule

// File: rtl/cfgslv_bus_events.sv
module cfgslv_bus_events #(
    parameter int unsigned FILT_CYCLES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_level,
    output logic sda_level,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    localparam int unsigned NLINES = 2;

    logic [NLINES-1:0] raw_lines;
    logic [NLINES-1:0] clean_lines;
    logic              scl_p, sda_p;

    assign raw_lines = {sda_in, scl_in};

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        cfgslv_line_filter #(
            .FILT_CYCLES(FILT_CYCLES),
            .IDLE_LEVEL (1'b1)
        ) i_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_i  (raw_lines[g]),
            .clean_o(clean_lines[g])
        );
    end

    assign scl_level = clean_lines[0];
    assign sda_level = clean_lines[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_level;
            sda_p <= sda_level;
        end
    end

    assign scl_rise  = scl_level & ~scl_p;
    assign scl_fall  = ~scl_level & scl_p;
    assign start_evt = scl_level & scl_p & sda_p & ~sda_level;
    assign stop_evt  = scl_level & scl_p & ~sda_p & sda_level;

    // R11: at most one bus event is reported per system cycle
    p_one_event_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({scl_rise, scl_fall, start_evt, stop_evt}));

endmodule

// File: rtl/cfgslv_reg_bank.sv
module cfgslv_reg_bank #(
    parameter int unsigned REG_COUNT = 3,
    parameter int unsigned IDX_W     = 4,
    parameter logic [8*REG_COUNT-1:0] IMPL_MASK = 24'hC0F00F
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [IDX_W-1:0]       wr_idx,
    input  logic [7:0]             wr_data,
    input  logic [IDX_W-1:0]       rd_idx,
    output logic [7:0]             rd_data,
    output logic [8*REG_COUNT-1:0] bank_o,
    output logic [REG_COUNT-1:0]   upd_o
);
    import cfgslv_pkg::*;

    for (genvar g = 0; g < REG_COUNT; g++) begin : g_reg
        localparam logic [7:0] MASK = IMPL_MASK[8*g +: 8];
        logic [7:0] r_q;
        logic       u_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                r_q <= EMPTY_BYTE;
                u_q <= 1'b0;
            end else begin
                u_q <= 1'b0;
                if (wr_en && (wr_idx == IDX_W'(g))) begin
                    r_q <= wr_data | ~MASK;
                    u_q <= 1'b1;
                end
            end
        end

        assign bank_o[8*g +: 8] = r_q;
        assign upd_o[g]         = u_q;

        // R4: a pulse on this register follows a write aimed at it
        p_pulse_has_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
            u_q |-> $past(wr_en && (wr_idx == IDX_W'(g))));
    end

    always_comb begin
        rd_data = EMPTY_BYTE;
        for (int i = 0; i < REG_COUNT; i++) begin
            if (rd_idx == IDX_W'(i)) begin
                rd_data = bank_o[8*i +: 8];
            end
        end
    end

    // R4: one byte updates at most one register
    p_single_update_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(upd_o));

    // R7: reset leaves every register at all ones
    p_reset_ones_r7: assert property (@(posedge clk)
        !rst_n |=> (bank_o == '1));

endmodule

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave #(
    parameter logic [6:0]  DEV_ADDR7   = 7'h69,
    parameter int unsigned REG_COUNT   = 3,
    parameter int unsigned READ_LEN    = 7,
    parameter int unsigned FILT_CYCLES = 3,
    parameter logic [8*REG_COUNT-1:0] IMPL_MASK = 24'hC0F00F
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   scl_in,
    input  logic                   sda_in,
    output logic                   sda_oe,
    output logic [8*REG_COUNT-1:0] reg_bank,
    output logic [REG_COUNT-1:0]   reg_updated
);
    import cfgslv_pkg::*;

    localparam int unsigned SPAN    = (READ_LEN > REG_COUNT) ? READ_LEN : REG_COUNT;
    localparam int unsigned IDX_W   = $clog2(SPAN + 3);
    localparam int unsigned CNT_W   = $clog2(BYTE_BITS + 1);
    localparam logic [IDX_W-1:0] IDX_MAX  = '1;
    localparam logic [IDX_W-1:0] HDR_LEN  = IDX_W'(2);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_BITS - 1);
    localparam logic [CNT_W-1:0] FULL     = CNT_W'(BYTE_BITS);

    logic scl_level, sda_level, scl_rise, scl_fall, start_evt, stop_evt;

    slv_state_e       state_q, state_d;
    logic [CNT_W-1:0] bit_cnt_q;
    logic [7:0]       shreg_q;
    logic [7:0]       tx_q;
    logic             rw_q;
    logic             host_ack_q;
    logic [IDX_W-1:0] wr_cnt_q;
    logic [IDX_W-1:0] rd_cnt_q;
    logic             sda_oe_q;

    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic [7:0]       rd_data;
    logic             addr_match;

    cfgslv_bus_events #(.FILT_CYCLES(FILT_CYCLES)) i_events (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (scl_in),
        .sda_in   (sda_in),
        .scl_level(scl_level),
        .sda_level(sda_level),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_evt(start_evt),
        .stop_evt (stop_evt)
    );

    assign addr_match = (shreg_q[7:1] == DEV_ADDR7);
    assign wr_en      = (state_q == ST_WR_ACK) && scl_rise && (wr_cnt_q >= HDR_LEN);
    assign wr_idx     = wr_cnt_q - HDR_LEN;

    cfgslv_reg_bank #(
        .REG_COUNT(REG_COUNT),
        .IDX_W    (IDX_W),
        .IMPL_MASK(IMPL_MASK)
    ) i_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .wr_data(shreg_q),
        .rd_idx (rd_cnt_q),
        .rd_data(rd_data),
        .bank_o (reg_bank),
        .upd_o  (reg_updated)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (start_evt) begin
            state_d = ST_ADDR;
        end else if (stop_evt) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_WAIT: state_d = state_q;
                ST_ADDR: begin
                    if (scl_fall && (bit_cnt_q == FULL)) begin
                        state_d = addr_match ? ST_ADDR_ACK : ST_WAIT;
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) state_d = rw_q ? ST_RD_BYTE : ST_WR_BYTE;
                end
                ST_WR_BYTE: begin
                    if (scl_fall && (bit_cnt_q == FULL)) state_d = ST_WR_ACK;
                end
                ST_WR_ACK: begin
                    if (scl_fall) state_d = ST_WR_BYTE;
                end
                ST_RD_BYTE: begin
                    if (scl_fall && (bit_cnt_q == LAST_BIT)) state_d = ST_RD_ACK;
                end
                ST_RD_ACK: begin
                    if (scl_fall) state_d = host_ack_q ? ST_RD_BYTE : ST_WAIT;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // Shift, count and index datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q  <= '0;
            shreg_q    <= '0;
            tx_q       <= EMPTY_BYTE;
            rw_q       <= 1'b0;
            host_ack_q <= 1'b0;
            wr_cnt_q   <= '0;
            rd_cnt_q   <= '0;
        end else if (start_evt) begin
            bit_cnt_q <= '0;
            wr_cnt_q  <= '0;
            rd_cnt_q  <= '0;
        end else if (!stop_evt) begin
            unique case (state_q)
                ST_ADDR, ST_WR_BYTE: begin
                    if (scl_rise && (bit_cnt_q != FULL)) begin
                        shreg_q   <= {shreg_q[6:0], sda_level};
                        bit_cnt_q <= bit_cnt_q + CNT_W'(1);
                    end
                    if ((state_q == ST_ADDR) && scl_fall && (bit_cnt_q == FULL)) begin
                        rw_q <= shreg_q[0];
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        bit_cnt_q <= '0;
                        if (rw_q) tx_q <= 8'(READ_LEN);
                    end
                end
                ST_WR_ACK: begin
                    if (scl_fall) begin
                        bit_cnt_q <= '0;
                        if (wr_cnt_q != IDX_MAX) wr_cnt_q <= wr_cnt_q + IDX_W'(1);
                    end
                end
                ST_RD_BYTE: begin
                    if (scl_fall) begin
                        tx_q      <= {tx_q[6:0], 1'b1};
                        bit_cnt_q <= bit_cnt_q + CNT_W'(1);
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) host_ack_q <= ~sda_level;
                    if (scl_fall) begin
                        bit_cnt_q <= '0;
                        if (host_ack_q) begin
                            tx_q <= rd_data;
                            if (rd_cnt_q != IDX_MAX) rd_cnt_q <= rd_cnt_q + IDX_W'(1);
                        end
                    end
                end
                ST_IDLE, ST_WAIT: begin
                    bit_cnt_q <= bit_cnt_q;
                end
                default: bit_cnt_q <= '0;
            endcase
        end
    end

    // Output process: registered open-drain enable
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_oe_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_ADDR_ACK, ST_WR_ACK: sda_oe_q <= 1'b1;
                ST_RD_BYTE:             sda_oe_q <= ~tx_q[7];
                default:                sda_oe_q <= 1'b0;
            endcase
        end
    end

    assign sda_oe = sda_oe_q;

    // R1: the address ACK state is only reached with our address shifted in
    p_ack_only_ours_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ADDR_ACK) |-> addr_match);

    // R4: register updates appear only after a cycle spent in the ACK state
    p_commit_on_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|reg_updated) |-> ($past(state_q) == ST_WR_ACK));

    // R6: the first byte sent in a read is the count
    p_count_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(state_q) == ST_ADDR_ACK) && (state_q == ST_RD_BYTE)) |-> (tx_q == 8'(READ_LEN)));

    // R10: once waiting, the slave no longer pulls SDA
    p_wait_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_WAIT) && ($past(state_q) == ST_WAIT)) |-> !sda_oe_q);

    // R12: pulling SDA low only starts while SCL is low
    p_pull_scl_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe_q) |-> !scl_level);

endmodule

// File: tb/test_smb_cfg_slave.sv
module test_smb_cfg_slave;

    localparam int Q = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_scl = 1'b1;
    logic        host_sda = 1'b1;
    logic        sda_oe;
    logic [23:0] bank;
    logic [2:0]  upd;
    wire         sda_line = host_sda & ~sda_oe;

    int n_checks = 0;
    int n_err    = 0;
    int pulses   = 0;
    int pull_hi  = 0;
    bit oe_seen  = 0;
    logic oe_prev = 1'b0;
    logic [7:0] model [3];

    always #10 clk = ~clk;

    smb_cfg_slave i_smb_cfg_slave (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_in     (host_scl),
        .sda_in     (sda_line),
        .sda_oe     (sda_oe),
        .reg_bank   (bank),
        .reg_updated(upd)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            pulses += $countones(upd);
            if (sda_oe) oe_seen = 1;
            if (sda_oe && !oe_prev && host_scl) pull_hi++;
        end
        oe_prev = sda_oe;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] stored(input int i, input logic [7:0] d);
        case (i)
            0:       return d | 8'hF0;
            1:       return d | 8'h0F;
            default: return d | 8'h3F;
        endcase
    endfunction

    function automatic logic [23:0] model_bank();
        return {model[2], model[1], model[0]};
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        host_sda = 1'b1; tick(Q);
        host_scl = 1'b1; tick(Q);
        host_sda = 1'b0; tick(Q);
        host_scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        host_scl = 1'b0; host_sda = 1'b0; tick(Q);
        host_scl = 1'b1; tick(Q);
        host_sda = 1'b1; tick(2*Q);
    endtask

    task automatic put_bit(input logic b, input bit glitch);
        host_sda = b;
        if (glitch) begin
            tick(Q/2); host_scl = 1'b1; tick(1); host_scl = 1'b0; tick(Q/2 - 1);
        end else begin
            tick(Q);
        end
        host_scl = 1'b1;
        if (glitch) begin
            tick(Q); host_sda = ~b; tick(1); host_sda = b; tick(Q - 1);
        end else begin
            tick(2*Q);
        end
        host_scl = 1'b0; tick(Q);
    endtask

    task automatic get_bit(output logic b);
        host_sda = 1'b1; tick(Q);
        host_scl = 1'b1; tick(Q);
        b = sda_line; tick(Q);
        host_scl = 1'b0; tick(Q);
    endtask

    task automatic write_byte(input logic [7:0] d, input bit glitch, output bit ack);
        logic nack;
        for (int i = 7; i >= 0; i--) put_bit(d[i], glitch);
        get_bit(nack);
        ack = !nack;
    endtask

    task automatic read_byte(input bit ack, output logic [7:0] d);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            d[i] = b;
        end
        put_bit(!ack, 1'b0);
        host_sda = 1'b1;
    endtask

    task automatic write_header(input logic [7:0] cmd, input logic [7:0] cnt, input string req);
        bit ack;
        bus_start();
        write_byte(8'hD2, 0, ack); check({req, " R1 write address ack"}, ack, 1);
        write_byte(cmd, 0, ack);   check({req, " R2 command ack"}, ack, 1);
        write_byte(cnt, 0, ack);   check({req, " R2 count ack"}, ack, 1);
    endtask

    task automatic t_reset();
        check("R7 bank after reset", bank, 24'hFFFFFF);
        check("R7 sda released in reset", sda_oe, 0);
    endtask

    task automatic t_basic_write();
        logic [7:0] d [3] = '{8'h05, 8'h3A, 8'h00};
        bit ack;
        pulses = 0;
        write_header(8'h5A, 8'h03, "basic");
        for (int i = 0; i < 3; i++) begin
            write_byte(d[i], 0, ack);
            check("R3 data byte ack", ack, 1);
            model[i] = stored(i, d[i]);
        end
        bus_stop();
        check("R3 ascending store", bank, model_bank());
        check("R4 one pulse per byte", pulses, 3);
    endtask

    task automatic t_dummy_only();
        pulses = 0;
        write_header(8'h00, 8'h00, "dummy");
        bus_stop();
        check("R2 header bytes not stored", bank, model_bank());
        check("R2 header bytes no pulse", pulses, 0);
    endtask

    task automatic t_restart();
        bit ack;
        write_header(8'h11, 8'h01, "restart");
        write_byte(8'h0A, 0, ack);
        bus_stop();
        model[0] = stored(0, 8'h0A);
        check("R5 new write restarts at register 0", bank, model_bank());
    endtask

    task automatic t_overflow();
        logic [7:0] d [5] = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55};
        bit ack;
        int acks = 0;
        pulses = 0;
        write_header(8'h77, 8'h05, "overflow");
        for (int i = 0; i < 5; i++) begin
            write_byte(d[i], 0, ack);
            if (ack) acks++;
            if (i < 3) model[i] = stored(i, d[i]);
        end
        bus_stop();
        check("R9 bytes past bank acked", acks, 5);
        check("R9 bank holds only first three", bank, model_bank());
        check("R9 no pulse past bank", pulses, 3);
    endtask

    task automatic t_abort();
        pulses = 0;
        write_header(8'h01, 8'h01, "abort");
        for (int i = 0; i < 4; i++) put_bit(1'b0, 0);
        bus_stop();
        check("R4 aborted byte leaves bank", bank, model_bank());
        check("R4 aborted byte no pulse", pulses, 0);
    endtask

    task automatic t_bad_addr();
        bit ack;
        pulses = 0;
        bus_start();
        write_byte(8'hA4, 0, ack); check("R1 foreign address no ack", ack, 0);
        write_byte(8'h00, 0, ack); check("R1 later byte no ack", ack, 0);
        write_byte(8'h00, 0, ack);
        bus_stop();
        check("R1 foreign transfer leaves bank", bank, model_bank());
        check("R1 foreign transfer no pulse", pulses, 0);
    endtask

    task automatic t_reserved();
        bit ack;
        write_header(8'h00, 8'h03, "reserved");
        for (int i = 0; i < 3; i++) begin
            write_byte(8'h00, 0, ack);
            model[i] = stored(i, 8'h00);
        end
        bus_stop();
        check("R8 reserved bits stay one", bank, 24'h3F0FF0);
    endtask

    task automatic t_glitch();
        bit ack;
        pulses = 0;
        write_header(8'h20, 8'h02, "glitch");
        write_byte(8'hC9, 1, ack); check("R11 glitched byte ack", ack, 1);
        write_byte(8'h96, 1, ack); check("R11 glitched byte ack", ack, 1);
        bus_stop();
        model[0] = stored(0, 8'hC9);
        model[1] = stored(1, 8'h96);
        check("R11 glitches ignored in data", bank, model_bank());
        check("R11 pulse count unchanged by glitches", pulses, 2);
    endtask

    task automatic t_read();
        bit ack;
        logic [7:0] d;
        logic b;
        int ones = 0;
        bus_start();
        write_byte(8'hD3, 0, ack); check("R1 read address ack", ack, 1);
        read_byte(1, d);           check("R6 count byte", d, 8'h07);
        for (int i = 0; i < 7; i++) begin
            read_byte(i != 6, d);
            check("R6 readback byte", d, (i < 3) ? model[i] : 8'hFF);
        end
        oe_seen = 0;
        for (int i = 0; i < 9; i++) begin
            get_bit(b);
            if (b) ones++;
        end
        check("R10 SDA released after NACK", ones, 9);
        check("R10 no pull after NACK", oe_seen, 0);
        bus_stop();
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 3; i++) model[i] = 8'hFF;
        tick(5);
        t_reset();
        rst_n = 1'b1;
        tick(10);
        t_basic_write();
        t_dummy_only();
        t_restart();
        t_overflow();
        t_abort();
        t_bad_addr();
        t_reserved();
        t_glitch();
        t_read();
        check("R12 pull began only with SCL low", pull_hi, 0);
        finish_run();
    end

endmodule